// File: doc/BRIEF.md
# Tone Duration Steering and Output Latch

This block sits behind a dual-tone decoder. The decoder supplies a presence flag and a 4-bit key code. The block decides when a detected tone has lasted long enough to count as a keypress. Guard timing is digital: a prescaler derives a millisecond tick from the system clock. A per-direction millisecond counter replaces the usual external resistor-capacitor timing network. When the present-guard count is reached with the flag held high, the code is written into an output latch and the delayed steering output rises.

The same counters then time the pause. The steering output falls only after the flag has stayed low for the absent-guard count. Shorter dropouts restart the count and are ignored. No new key is accepted until the steering output has fallen.

Three control inputs shape the behaviour:
- An inhibit input blocks the four extended keys.
- A power-down input freezes all detection.
- An output-enable input produces the enable for an external three-state driver on the code bus.

The latched code is not a stream, so the block has no valid/ready handshake. Every pin is a plain level.

To accept tones of 40 ms and reject tones of 20 ms or less, choose the present guard so that it plus the decoder's detect time falls between those limits.

Top module: `tone_steer_latch`

## Requirements
- R1: When `early_flag` is high with an accepted code for exactly `guard_on_ms`*CLK_PER_MS consecutive clock edges, `steer_out` rises after the last of those edges and `code_q` takes `tone_code`. A guard value of 0 acts as 1 ms.
- R2: A burst shorter than the present guard leaves `steer_out` low and `code_q` unchanged.
- R3: `code_q` changes only in the cycle `steer_out` rises, and holds its value until the next registration.
- R4: While `steer_out` is high, it falls only after `early_flag` has been low for `guard_off_ms`*CLK_PER_MS consecutive edges. A shorter dropout keeps it high and restarts the count.
- R5: While `steer_out` is high, a change of `tone_code` with `early_flag` still high causes no new registration.
- R6: `code_drive` (enable for the external three-state bus driver, low means high impedance) equals `out_en`. The latch still updates while `out_en` is low.
- R7: While `inhibit_ad` is high, codes 13, 14, 15 and 0 (keys A, B, C, D) are not registered and `code_q` keeps the previous code. Codes 1 to 12 still register.
- R8: While `power_down` is high, the guard counters are cleared and `steer_out` and `code_q` hold.
- R9: After reset, `steer_out` is 0 and `code_q` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| power_down | input | 1 | Freeze all detection when high |
| inhibit_ad | input | 1 | Block codes 13,14,15,0 when high |
| out_en | input | 1 | Code bus enable request |
| early_flag | input | 1 | Decoder reports a valid tone pair |
| tone_code | input | 4 | Decoder key code |
| guard_on_ms | input | GUARD_W | Present guard in ms |
| guard_off_ms | input | GUARD_W | Absent guard in ms |
| code_q | output | 4 | Latched key code |
| code_drive | output | 1 | Three-state driver enable for code_q |
| steer_out | output | 1 | Delayed steering: key registered |

## Verification
The assertions assume three things about the inputs:
- `tone_code` is steady whenever `early_flag` is high before registration.
- The guard values do not change during a count.
- All inputs move only between active clock edges.

The stimulus changes every input on the falling clock edge. It holds the code fixed for each tone and sets the guard values only while the block is idle. Under those conditions, the checker ties every rise and fall of the steering output to the level of the presence flag, and every latch change to a steering rise.

// File: rtl/tsl_pkg.sv
package tsl_pkg;
  localparam int CODE_W = 4;
  typedef logic [CODE_W-1:0] key_code_t;

  // Extended keys A..D as coded by the upstream decoder
  function automatic logic is_ext_key(key_code_t c);
    return (c == 4'd13) || (c == 4'd14) || (c == 4'd15) || (c == 4'd0);
  endfunction
endpackage

// File: rtl/tsl_ms_tick.sv
module tsl_ms_tick #(
  parameter int CLK_PER_MS = 3580
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  generate
    if (CLK_PER_MS <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_prescale
      localparam int PW = $clog2(CLK_PER_MS);
      localparam logic [PW-1:0] LAST = PW'(CLK_PER_MS - 1);
      logic [PW-1:0] pre;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           pre <= '0;
        else if (!run)        pre <= '0;
        else if (pre == LAST) pre <= '0;
        else                  pre <= pre + 1'b1;
      end
      assign tick = run && (pre == LAST);
    end
  endgenerate
endmodule

// File: rtl/tsl_guard.sv
module tsl_guard #(
  parameter int GUARD_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               tick,
  input  logic [GUARD_W-1:0] limit,
  output logic               expire
);
  logic [GUARD_W-1:0] ms;
  logic [GUARD_W:0]   next_ms;

  assign next_ms = {1'b0, ms} + 1'b1;
  assign expire  = tick && (next_ms >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             ms <= '0;
    else if (!run || expire) ms <= '0;
    else if (tick)          ms <= next_ms[GUARD_W-1:0];
  end
endmodule

// File: rtl/tone_steer_latch.sv
module tone_steer_latch
  import tsl_pkg::*;
#(
  parameter int CLK_PER_MS = 3580,
  parameter int GUARD_W    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               power_down,
  input  logic               inhibit_ad,
  input  logic               out_en,
  input  logic               early_flag,
  input  logic [3:0]         tone_code,
  input  logic [GUARD_W-1:0] guard_on_ms,
  input  logic [GUARD_W-1:0] guard_off_ms,
  output logic [3:0]         code_q,
  output logic               code_drive,
  output logic               steer_out
);
  logic       accept_key;
  logic       run;
  logic       tick;
  logic       expire;
  logic [GUARD_W-1:0] limit;
  key_code_t  latch_q;
  logic       steer_q;

  assign accept_key = early_flag && !(inhibit_ad && is_ext_key(tone_code));
  assign run   = !power_down && (steer_q ? !early_flag : accept_key);
  assign limit = steer_q ? guard_off_ms : guard_on_ms;

  tsl_ms_tick #(.CLK_PER_MS(CLK_PER_MS)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  tsl_guard #(.GUARD_W(GUARD_W)) u_guard (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
    .limit(limit), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      steer_q <= 1'b0;
      latch_q <= '0;
    end else if (expire) begin
      steer_q <= !steer_q;
      if (!steer_q) latch_q <= tone_code;
    end
  end

  assign code_q     = latch_q;
  assign steer_out  = steer_q;
  assign code_drive = out_en;
endmodule

// File: rtl/tsl_checker.sv
module tsl_checker
  import tsl_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       power_down,
  input logic       inhibit_ad,
  input logic       early_flag,
  input logic [3:0] tone_code,
  input logic [3:0] code_q,
  input logic       steer_out
);
  AST_LATCH_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_q) |-> $rose(steer_out)); // R3

  AST_RISE_NEEDS_TONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(steer_out) |-> $past(early_flag)); // R1

  AST_FALL_NEEDS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(steer_out) |-> !$past(early_flag)); // R4

  AST_INHIBIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit_ad && is_ext_key(tone_code) && !steer_out) |=> !steer_out); // R7

  AST_PD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    power_down |=> ($stable(steer_out) && $stable(code_q))); // R8
endmodule

bind tone_steer_latch tsl_checker u_tsl_checker (
  .clk(clk), .rst_n(rst_n), .power_down(power_down), .inhibit_ad(inhibit_ad),
  .early_flag(early_flag), .tone_code(tone_code), .code_q(code_q),
  .steer_out(steer_out)
);

// File: tb/test_tone_steer_latch.sv
module test_tone_steer_latch;
  localparam int CLK_PERIOD = 10;
  localparam int CPM = 4;   // clocks per ms in the bench
  localparam int ON_MS = 10;
  localparam int OFF_MS = 5;
  localparam int ON_CYC = ON_MS * CPM;
  localparam int OFF_CYC = OFF_MS * CPM;

  logic clk = 0, rst_n = 0;
  logic power_down = 0, inhibit_ad = 0, out_en = 1, early_flag = 0;
  logic [3:0] tone_code = 0;
  logic [7:0] guard_on_ms = 8'(ON_MS), guard_off_ms = 8'(OFF_MS);
  logic [3:0] code_q;
  logic code_drive, steer_out;

  int total = 0, bad = 0, cycles = 0;
  logic [3:0] exp_q[$];
  logic prev_steer = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tone_steer_latch #(.CLK_PER_MS(CPM), .GUARD_W(8)) i_tone_steer_latch (
    .clk(clk), .rst_n(rst_n), .power_down(power_down), .inhibit_ad(inhibit_ad),
    .out_en(out_en), .early_flag(early_flag), .tone_code(tone_code),
    .guard_on_ms(guard_on_ms), .guard_off_ms(guard_off_ms),
    .code_q(code_q), .code_drive(code_drive), .steer_out(steer_out)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: present a tone; push the code if it must register
  task automatic drive_tone(logic [3:0] c, int len, bit expect_reg);
    if (expect_reg) exp_q.push_back(c);
    tone_code = c;
    early_flag = 1;
    cyc(len);
    early_flag = 0;
  endtask

  // monitor: each steering rise must match the next expected code
  always @(negedge clk) begin
    if (rst_n && steer_out && !prev_steer) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R3 unexpected registration actual=%0d expected=none", code_q);
      end else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        if (code_q != e) begin
          bad++;
          $display("FAIL R1 registered code actual=%0d expected=%0d", code_q, e);
        end
      end
    end
    prev_steer = steer_out;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    chk("R9 steer reset", steer_out, 0);
    chk("R9 code reset", code_q, 0);
    chk("R6 drive follows enable", code_drive, 1);

    // R1 exact boundary
    exp_q.push_back(4'd5);
    tone_code = 4'd5; early_flag = 1;
    cyc(ON_CYC - 1);
    chk("R1 not yet registered", steer_out, 0);
    cyc(1);
    chk("R1 registered at guard", steer_out, 1);
    chk("R1 code latched", code_q, 5);
    // R4 exact fall boundary
    early_flag = 0;
    cyc(OFF_CYC - 1);
    chk("R4 still held", steer_out, 1);
    cyc(1);
    chk("R4 released after absent guard", steer_out, 0);
    chk("R3 latch kept after release", code_q, 5);

    // R2 short burst
    drive_tone(4'd3, ON_CYC - 1, 0);
    cyc(2);
    chk("R2 burst rejected steer", steer_out, 0);
    chk("R2 burst rejected code", code_q, 5);

    // R5 and R4 dropout
    exp_q.push_back(4'd7);
    tone_code = 4'd7; early_flag = 1;
    cyc(ON_CYC + 4);
    tone_code = 4'd9;
    cyc(60);
    chk("R5 no re-register code", code_q, 7);
    early_flag = 0;
    cyc(OFF_CYC - 2);
    early_flag = 1;
    cyc(3);
    chk("R4 dropout ignored", steer_out, 1);
    early_flag = 0;
    cyc(OFF_CYC - 2);
    chk("R4 count restarted", steer_out, 1);
    cyc(2);
    chk("R4 released", steer_out, 0);
    drive_tone(4'd9, ON_CYC + 2, 1);
    cyc(OFF_CYC + 2);
    chk("R3 new code after pause", code_q, 9);

    // R7 inhibit
    inhibit_ad = 1;
    drive_tone(4'd13, ON_CYC * 2, 0);
    cyc(2);
    chk("R7 key A blocked", code_q, 9);
    drive_tone(4'd0, ON_CYC * 2, 0);
    cyc(2);
    chk("R7 key D blocked", code_q, 9);
    chk("R7 steer stays low", steer_out, 0);
    drive_tone(4'd2, ON_CYC + 2, 1);
    cyc(OFF_CYC + 2);
    chk("R7 normal key passes", code_q, 2);
    inhibit_ad = 0;
    drive_tone(4'd14, ON_CYC + 2, 1);
    cyc(OFF_CYC + 2);
    chk("R7 key B passes uninhibited", code_q, 14);

    // R6 disabled bus
    out_en = 0;
    cyc(1);
    chk("R6 drive off", code_drive, 0);
    drive_tone(4'd4, ON_CYC + 2, 1);
    cyc(OFF_CYC + 2);
    out_en = 1;
    cyc(1);
    chk("R6 drive on", code_drive, 1);
    chk("R6 latch updated while disabled", code_q, 4);

    // R8 power down
    power_down = 1;
    drive_tone(4'd11, ON_CYC * 2, 0);
    cyc(2);
    chk("R8 no register in power down", code_q, 4);
    power_down = 0;
    exp_q.push_back(4'd6);
    tone_code = 4'd6; early_flag = 1;
    cyc(ON_CYC + 2);
    power_down = 1;
    early_flag = 0;
    cyc(OFF_CYC * 3);
    chk("R8 steer frozen", steer_out, 1);
    power_down = 0;
    cyc(OFF_CYC - 1);
    chk("R8 count restarts after wake", steer_out, 1);
    cyc(1);
    chk("R8 release after wake", steer_out, 0);
    chk("R8 code kept", code_q, 6);

    cyc(2);
    chk("R3 all expected registrations seen", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule